// File: doc/BRIEF.md
# Programmable-Shift Coded Coefficient Multiplier

This block multiplies a signed input sample by a coefficient that has already been reduced offline into a short list of operand codes. Each code picks one of a few precomputed sums of the sample and names a power-of-two weight for it. Inside the block, every operand slot has a selector multiplexer and a programmable barrel shifter. A sum stage adds the slots, and one register stage holds the product. A single common factor of one half is applied to the total, not to each operand. Changing the coefficient at run time only means presenting a different operand list. The adders stay the same.

The product is a signed fixed-point value with 18 fractional bits. A coefficient whose plain binary fraction is H/2^16 (H a 16-bit unsigned integer) therefore yields `prod_o = 4 * x * H`. The output is wide enough that no operand pattern and no sample value can truncate or overflow it.

Top module: `cmul_pshift`

## Requirements
- R1: For an operand list that codes a 16-bit binary coefficient H, the registered product equals 4·x·H exactly. For example, H = 0xA653 is coded as pattern 3 at position 0, pattern 2 at position 5, pattern 3 at position 9 and pattern 2 at position 14.
- R2: A slot whose selector is 0 (empty) or 4 to 7 (reserved) adds nothing to the product.
- R3: Selector 1 gives x, selector 2 gives x + x/2 and selector 3 gives x + x/4. At position p the slot contributes, in output LSBs, x times 4, 6 or 5 respectively, multiplied by 2^(15−p).
- R4: Every position from 0 to 15 is honoured exactly, including selectors 2 and 3 at position 15, where the lowest set bit lies below 2^-16.
- R5: Slot k occupies ops_i[7k+6:7k]. Within a slot, bits [6:4] are the selector and bits [3:0] are the position p.
- R6: valid_o is valid_i delayed by one clock. The product of the operands presented with valid_i appears in the same cycle that valid_o is high.
- R7: While valid_i is low, prod_o keeps its last value whatever the sample and operand inputs do.
- R8: While rst_n is low, valid_o and prod_o are zero. Assertion of rst_n takes effect without a clock, and release takes effect on clock edges.
- R9: The sample is two's complement. The extreme case of x = −32768 with all four slots at selector 2, position 0 is represented without overflow.
- R10: Slots add independently. Two slots carrying identical codes contribute twice the single-slot value.
- R11: A zero sample gives a zero product for any operand list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| valid_i | input | 1 | Sample and operand list are valid this cycle |
| sample_i | input | DATA_W (16) | Signed input sample |
| ops_i | input | 7·NUM_OPS (28) | Packed operand codes, slot 0 in the low bits |
| valid_o | output | 1 | Product register updated last cycle |
| prod_o | output | OUT_W (36) | Signed product, 18 fractional bits |

## Verification
The hardest cases to reach are the bottom of the shift range combined with a widening pattern. A slot with selector 2 or 3 at position 15 is the only way to check that the guard bits below 2^-16 survive. The full-scale case, with a negative extreme sample and every slot at maximum weight, is the only way to check the top headroom. Directed vector entries place those codes explicitly. Random operand lists reach mixed and reserved selectors. Random 16-bit coefficients are coded greedily in the bench, and only codings that fit four slots are kept, so the block is compared with a plain integer multiply across varied bit densities.

// File: rtl/cmul_pkg.sv
`timescale 1ns/1ps
package cmul_pkg;
  localparam int SEL_W   = 3;
  localparam int SHIFT_W = 4;
  localparam int CODE_W  = SEL_W + SHIFT_W;
  localparam int MAX_SH  = (1 << SHIFT_W) - 1;
  localparam int PRESCALE_W = 3;  // 4x, 5x, 6x need three extra integer bits

  typedef enum logic [SEL_W-1:0] {
    SEL_NONE  = 3'd0,
    SEL_X     = 3'd1,
    SEL_X_H   = 3'd2,
    SEL_X_Q   = 3'd3
  } sub_sel_e;

  typedef struct packed {
    logic [SEL_W-1:0]   sel;
    logic [SHIFT_W-1:0] pos;
  } op_code_t;
endpackage

// File: rtl/cmul_subexpr.sv
`timescale 1ns/1ps
// Shared shift-and-add unit: the sample prescaled by 4 so that x/2 and x/4
// terms stay integral.
module cmul_subexpr
  import cmul_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int SUB_W = DATA_W + PRESCALE_W
) (
  input  logic [DATA_W-1:0]       x_i,
  output logic signed [SUB_W-1:0] x4_o,
  output logic signed [SUB_W-1:0] x6_o,
  output logic signed [SUB_W-1:0] x5_o
);
  logic signed [SUB_W-1:0] xe;

  always_comb begin
    xe   = SUB_W'($signed(x_i));
    x4_o = xe <<< 2;
    x6_o = x4_o + (xe <<< 1);
    x5_o = x4_o + xe;
  end
endmodule

// File: rtl/cmul_lane.sv
`timescale 1ns/1ps
// One operand slot: subexpression multiplexer plus logarithmic barrel shifter.
module cmul_lane
  import cmul_pkg::*;
#(
  parameter int SUB_W  = 19,
  localparam int TERM_W = SUB_W + MAX_SH
) (
  input  op_code_t                 code_i,
  input  logic signed [SUB_W-1:0]  x4_i,
  input  logic signed [SUB_W-1:0]  x6_i,
  input  logic signed [SUB_W-1:0]  x5_i,
  output logic signed [TERM_W-1:0] term_o
);
  logic signed [SUB_W-1:0] pick;
  logic [SHIFT_W-1:0]      amt;
  logic [TERM_W-1:0]       stg [SHIFT_W+1];

  always_comb begin
    unique case (sub_sel_e'(code_i.sel))
      SEL_X:   pick = x4_i;
      SEL_X_H: pick = x6_i;
      SEL_X_Q: pick = x5_i;
      default: pick = '0;
    endcase
    // position p means weight 2^-p; left shift by MAX_SH - p, which is ~p
    amt    = ~code_i.pos;
    stg[0] = TERM_W'(pick);
  end

  for (genvar k = 0; k < SHIFT_W; k++) begin : g_stage
    always_comb stg[k+1] = amt[k] ? (stg[k] << (1 << k)) : stg[k];
  end

  assign term_o = $signed(stg[SHIFT_W]);
endmodule

// File: rtl/cmul_sum.sv
`timescale 1ns/1ps
// Sums the slot terms, sign-extending each to the output width.
module cmul_sum #(
  parameter int NUM_OPS = 4,
  parameter int TERM_W  = 34,
  parameter int OUT_W   = 36
) (
  input  logic [NUM_OPS-1:0][TERM_W-1:0] terms_i,
  output logic signed [OUT_W-1:0]        sum_o
);
  always_comb begin
    sum_o = '0;
    for (int k = 0; k < NUM_OPS; k++) begin
      sum_o = sum_o + OUT_W'($signed(terms_i[k]));
    end
  end
endmodule

// File: rtl/cmul_pshift.sv
`timescale 1ns/1ps
module cmul_pshift
  import cmul_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NUM_OPS = 4,
  localparam int SUB_W  = DATA_W + PRESCALE_W,
  localparam int TERM_W = SUB_W + MAX_SH,
  localparam int OUT_W  = TERM_W + $clog2(NUM_OPS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      valid_i,
  input  logic [DATA_W-1:0]         sample_i,
  input  logic [NUM_OPS*CODE_W-1:0] ops_i,
  output logic                      valid_o,
  output logic [OUT_W-1:0]          prod_o
);
  // reset: asynchronous assertion, synchronous release
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic signed [SUB_W-1:0]        x4, x6, x5;
  logic [NUM_OPS-1:0][TERM_W-1:0] terms;
  logic signed [OUT_W-1:0]        sum;

  cmul_subexpr #(.DATA_W(DATA_W)) u_subexpr (
    .x_i  (sample_i),
    .x4_o (x4),
    .x6_o (x6),
    .x5_o (x5)
  );

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_lane
    logic signed [TERM_W-1:0] term;
    cmul_lane #(.SUB_W(SUB_W)) u_lane (
      .code_i (op_code_t'(ops_i[k*CODE_W +: CODE_W])),
      .x4_i   (x4),
      .x6_i   (x6),
      .x5_i   (x5),
      .term_o (term)
    );
    assign terms[k] = term;
  end

  cmul_sum #(.NUM_OPS(NUM_OPS), .TERM_W(TERM_W), .OUT_W(OUT_W)) u_sum (
    .terms_i (terms),
    .sum_o   (sum)
  );

  // output stage: next-state then register; the final halving is the
  // placement of the binary point (MAX_SH + 3 fractional bits), so no bit drops
  logic             valid_d, valid_q;
  logic [OUT_W-1:0] prod_d, prod_q;

  always_comb begin
    valid_d = valid_i;
    prod_d  = valid_i ? sum : prod_q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      valid_q <= 1'b0;
      prod_q  <= '0;
    end else begin
      valid_q <= valid_d;
      prod_q  <= prod_d;
    end
  end

  assign valid_o = valid_q;
  assign prod_o  = prod_q;

  // checker helper: every slot empty or reserved
  function automatic logic all_void(input logic [NUM_OPS*CODE_W-1:0] ops);
    logic v;
    v = 1'b1;
    for (int k = 0; k < NUM_OPS; k++) begin
      if (ops[k*CODE_W+SHIFT_W +: SEL_W] inside {3'd1, 3'd2, 3'd3}) v = 1'b0;
    end
    return v;
  endfunction

  p_valid_follow_r6: assert property (@(posedge clk) disable iff (!rst_q)
    valid_i |=> valid_o);
  p_valid_drop_r6: assert property (@(posedge clk) disable iff (!rst_q)
    !valid_i |=> !valid_o);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_q)
    !valid_i |=> $stable(prod_o));
  p_void_zero_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (valid_i && all_void(ops_i)) |=> (prod_o == '0));
  p_zero_sample_r11: assert property (@(posedge clk) disable iff (!rst_q)
    (valid_i && sample_i == '0) |=> (prod_o == '0));
endmodule

// File: tb/cmul_pshift_tb.sv
`timescale 1ns/1ps
module cmul_pshift_tb;
  localparam int DATA_W  = 16;
  localparam int NUM_OPS = 4;
  localparam int OPS_W   = NUM_OPS * 7;
  localparam int OUT_W   = 36;
  localparam int NVEC    = 10;

  logic             clk;
  logic             rst_n;
  logic             valid_i;
  logic [15:0]      sample_i;
  logic [OPS_W-1:0] ops_i;
  logic             valid_o;
  logic [OUT_W-1:0] prod_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  cmul_pshift #(.DATA_W(DATA_W), .NUM_OPS(NUM_OPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .sample_i(sample_i),
    .ops_i(ops_i), .valid_o(valid_o), .prod_o(prod_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {sample, slot3..slot0 codes {sel[2:0],pos[3:0]}, expected weight in output LSBs per unit x}
  localparam logic [75:0] VEC [NVEC] = '{
    {16'd1000,  {7'h2E, 7'h39, 7'h25, 7'h30}, 32'd170316}, // R1 H=0xA653
    {16'hFFF9,  {7'h00, 7'h00, 7'h00, 7'h10}, 32'd131072}, // R3 sel1 pos0
    {16'h3039,  {7'h00, 7'h00, 7'h00, 7'h2F}, 32'd6},      // R4 sel2 pos15
    {16'h8000,  {7'h00, 7'h00, 7'h00, 7'h3F}, 32'd5},      // R4 sel3 pos15
    {16'h0309,  {7'h00, 7'h00, 7'h00, 7'h00}, 32'd0},      // R2 empty
    {16'hFB2E,  {7'h4F, 7'h70, 7'h53, 7'h61}, 32'd0},      // R2 reserved
    {16'h0141,  {7'h20, 7'h00, 7'h1F, 7'h53}, 32'd196612}, // R5 mixed slots
    {16'h8000,  {7'h20, 7'h20, 7'h20, 7'h20}, 32'd786432}, // R9 full scale neg
    {16'h7FFF,  {7'h20, 7'h20, 7'h20, 7'h20}, 32'd786432}, // R9 full scale pos
    {16'h0063,  {7'h00, 7'h00, 7'h13, 7'h13}, 32'd32768}   // R10 duplicates
  };

  localparam string VTAG [NVEC] = '{"R1", "R3", "R4", "R4", "R2",
                                    "R2", "R5", "R9", "R9", "R10"};

  function automatic longint ref_weight(input logic [OPS_W-1:0] c);
    longint w = 0;
    for (int k = 0; k < NUM_OPS; k++) begin
      logic [2:0] s = c[7*k+4 +: 3];
      logic [3:0] p = c[7*k +: 4];
      longint m = (s == 3'd1) ? 4 : (s == 3'd2) ? 6 : (s == 3'd3) ? 5 : 0;
      w += m <<< (15 - int'(p));
    end
    return w;
  endfunction

  // greedy coder: returns operand count, codes in c
  function automatic int greedy_code(input logic [15:0] h, output logic [OPS_W-1:0] c);
    logic [15:0] r = h;
    int n = 0;
    c = '0;
    for (int p = 0; p < 16; p++) begin
      int b = 15 - p;
      logic [2:0] s;
      if (r[b]) begin
        if (p <= 13 && r[b-2]) begin s = 3'd3; r[b-2] = 1'b0; end
        else if (p <= 14 && r[b-1]) begin s = 3'd2; r[b-1] = 1'b0; end
        else s = 3'd1;
        if (n < NUM_OPS) c[7*n +: 7] = {s, 4'(p)};
        n++;
      end
    end
    return n;
  endfunction

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic run(input logic [15:0] x, input logic [OPS_W-1:0] c,
                     input longint w, input string tag);
    @(negedge clk);
    sample_i = x; ops_i = c; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check(tag, longint'($signed(prod_o)), longint'($signed(x)) * w);
  endtask

  // watchdog
  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; valid_i = 1'b0; sample_i = '0; ops_i = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 valid", longint'(valid_o), 0);
    check("R8 prod", longint'(prod_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      run(VEC[i][75:60], VEC[i][59:32], longint'(VEC[i][31:0]), VTAG[i]);
    end

    // R6 latency: valid_o high right after, low one cycle later
    @(negedge clk);
    sample_i = 16'd3; ops_i = 28'h0000010; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check("R6 valid high", longint'(valid_o), 1);
    check("R6 prod", longint'($signed(prod_o)), 3 * 131072);
    @(negedge clk);
    check("R6 valid low", longint'(valid_o), 0);

    // R7 hold: change inputs with valid low
    sample_i = 16'h7123; ops_i = {4{7'h20}};
    repeat (2) @(negedge clk);
    check("R7 hold", longint'($signed(prod_o)), 3 * 131072);

    // R11 zero sample with busy operands
    run(16'd0, {7'h3F, 7'h20, 7'h11, 7'h2A}, 0, "R11");

    // R3/R5 random operand lists
    for (int i = 0; i < 150; i++) begin
      logic [OPS_W-1:0] c = OPS_W'($urandom);
      logic [15:0] x = 16'($urandom);
      run(x, c, ref_weight(c), "R3");
    end

    // R1 random coefficients coded in the bench, against plain multiply
    for (int i = 0, acc = 0; i < 2000 && acc < 120; i++) begin
      logic [OPS_W-1:0] c;
      logic [15:0] h = 16'($urandom);
      logic [15:0] x = 16'($urandom);
      if (greedy_code(h, c) <= NUM_OPS) begin
        acc++;
        run(x, c, 4 * longint'(h), "R1");
      end
    end

    // R8 asynchronous reset mid-run
    run(16'd77, 28'h0000010, 131072, "R6");
    #2 rst_n = 1'b0;
    #1;
    check("R8 async valid", longint'(valid_o), 0);
    check("R8 async prod", longint'(prod_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run(16'hFFFF, {7'h00, 7'h00, 7'h00, 7'h2F}, 6, "R4");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule